// File: doc/BRIEF.md
# Dual-Direction Storage Bus Transceiver

This block joins two parallel buses, A and B, with one data path per direction. Every bit of a path has a single storage element. That element passes the source straight through, holds its last value, or loads on a rising edge of the direction clock. Three controls on each direction pick the behaviour: a latch enable, a direction clock and an output enable.

The block runs on a fast system clock. The direction clocks are ordinary inputs that the block samples, and it finds their rising edges itself.

Neither port is a true inout. Each port has its own data-in, data-out and drive-enable signals, so the surrounding logic or a bench resolves the shared wire and can see when a port is released. The A-to-B output enable is active high. The B-to-A output enable is active low.

Top module: `xcvr_reg_bus`

## Requirements
- R1: The data path defaults to 18 bits in each direction. A-to-B is controlled only by `ab_le_i`, `ab_clk_i` and `ab_oe_i`. B-to-A is controlled only by `ba_le_i`, `ba_clk_i` and `ba_oe_ni`. Activity in one direction leaves the other direction's output unchanged.
- R2: While a direction's latch enable is 1, its destination data output equals its source data input in the same cycle, with no register on the way.
- R3: While latch enable is 0 and the direction clock shows no rising edge, the destination output keeps the stored value. This holds with the direction clock steady at 0 and steady at 1.
- R4: A rising edge is a direction clock sampled at 0 on one system clock edge and at 1 on the next. With latch enable at 0, such an edge loads the source into storage, and the loaded value appears on the output right after that system clock edge. A clock held at 1 afterwards causes no further load.
- R5: If latch enable falls while the direction clock is 0, the next rising edge of that clock loads the source value present at that edge.
- R6: `b_oe_o` is 1 exactly when `ab_oe_i` is 1 and reset is released. Otherwise port B is released.
- R7: `a_oe_o` is 1 exactly when `ba_oe_ni` is 0 and reset is released. Otherwise port A is released.
- R8: A released port does not disturb storage. A load made while the port is released appears on the output once the port drives again.
- R9: While `rst_ni` is 0, both storage registers are cleared and both drive enables are 0. A direction clock that is already 1 when reset is released does not count as a rising edge.
- R10: Direction clock edges while latch enable is 1 have no effect beyond transparency. When latch enable falls, the output keeps the source value sampled at the last system clock edge on which latch enable was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | DATA_W | Value seen on bus A (source for A-to-B) |
| a_data_o | output | DATA_W | Value to drive on bus A (B-to-A result) |
| a_oe_o | output | 1 | Drive enable for bus A |
| b_data_i | input | DATA_W | Value seen on bus B (source for B-to-A) |
| b_data_o | output | DATA_W | Value to drive on bus B (A-to-B result) |
| b_oe_o | output | 1 | Drive enable for bus B |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_clk_i | input | 1 | A-to-B direction clock |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_clk_i | input | 1 | B-to-A direction clock |

## Verification
Transparency and the drive enables are combinational. The bench therefore checks them a moment after changing the inputs, in the same cycle.

A load needs one register: the system clock edge that first samples the direction clock at 1 is the edge that writes storage. The loaded value is checked just after that edge, and the value from before the edge is checked just before it.

Inputs change two time units after a rising edge, and every sample is taken after that. No check lands on an active edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned NUM_DIR = 2;

  typedef enum logic [1:0] {
    ST_PASS,
    ST_HOLD,
    ST_LOAD
  } store_op_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  output logic rise_o
);
  logic prev_q;

  // Reset to 1: a clock already high at reset release is not an edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= smp_i;
  end

  assign rise_o = smp_i & ~prev_q;

  assert_single_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic              le_i,
  input  logic              dclk_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dst_o,
  output logic              drive_o
);
  logic              rise_w;
  logic [DATA_W-1:0] store_q;
  store_op_e         op;
  logic              en_w;

  xcvr_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (dclk_i),
    .rise_o(rise_w)
  );

  always_comb begin
    if (le_i)        op = ST_PASS;
    else if (rise_w) op = ST_LOAD;
    else             op = ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              store_q <= '0;
    else if (op != ST_HOLD)   store_q <= src_i;
  end

  assign dst_o = (op == ST_PASS) ? src_i : store_q;

  generate
    if (OE_LOW) begin : g_oe_low
      assign en_w = ~oe_i;
    end else begin : g_oe_high
      assign en_w = oe_i;
    end
  endgenerate

  assign drive_o = rst_ni & en_w;

  assert_pass_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> store_q == $past(src_i));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise_w) |=> store_q == $past(store_q));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise_w) |=> store_q == $past(src_i));
endmodule

// File: rtl/xcvr_reg_bus.sv
module xcvr_reg_bus
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_data_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_oe_o,
  input  logic              ab_oe_i,
  input  logic              ab_le_i,
  input  logic              ab_clk_i,
  input  logic              ba_oe_ni,
  input  logic              ba_le_i,
  input  logic              ba_clk_i
);
  // Index 0: A to B, index 1: B to A
  logic [DATA_W-1:0] src_w [NUM_DIR];
  logic [DATA_W-1:0] dst_w [NUM_DIR];
  logic              le_w  [NUM_DIR];
  logic              dck_w [NUM_DIR];
  logic              oe_w  [NUM_DIR];
  logic              drv_w [NUM_DIR];

  assign src_w[0] = a_data_i;
  assign src_w[1] = b_data_i;
  assign le_w[0]  = ab_le_i;
  assign le_w[1]  = ba_le_i;
  assign dck_w[0] = ab_clk_i;
  assign dck_w[1] = ba_clk_i;
  assign oe_w[0]  = ab_oe_i;
  assign oe_w[1]  = ba_oe_ni;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_store #(
      .DATA_W(DATA_W),
      .OE_LOW(d == 1)
    ) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_w[d]),
      .le_i   (le_w[d]),
      .dclk_i (dck_w[d]),
      .oe_i   (oe_w[d]),
      .dst_o  (dst_w[d]),
      .drive_o(drv_w[d])
    );
  end

  assign b_data_o = dst_w[0];
  assign b_oe_o   = drv_w[0];
  assign a_data_o = dst_w[1];
  assign a_oe_o   = drv_w[1];
endmodule

// File: tb/xcvr_reg_bus_test.sv
module xcvr_reg_bus_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;
  logic         ab_oe = 1'b1, ab_le = 1'b0, ab_clk = 1'b1;
  logic         ba_oe_n = 1'b0, ba_le = 1'b0, ba_clk = 1'b1;
  int           n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  xcvr_reg_bus #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_data_i(a_in), .a_data_o(a_out), .a_oe_o(a_oe),
    .b_data_i(b_in), .b_data_o(b_out), .b_oe_o(b_oe),
    .ab_oe_i(ab_oe), .ab_le_i(ab_le), .ab_clk_i(ab_clk),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  // d = 0: A to B, d = 1: B to A
  task automatic set_src(input int d, input logic [W-1:0] v);
    if (d == 0) a_in = v; else b_in = v;
  endtask
  task automatic set_le(input int d, input logic v);
    if (d == 0) ab_le = v; else ba_le = v;
  endtask
  task automatic set_dclk(input int d, input logic v);
    if (d == 0) ab_clk = v; else ba_clk = v;
  endtask
  function automatic logic [W-1:0] dst(input int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  task automatic t_reset();
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R9 b_oe in reset", W'(b_oe), W'(0));
    chk("R9 a_oe in reset", W'(a_oe), W'(0));
    chk("R9 b_data cleared", b_out, '0);
    chk("R9 a_data cleared", a_out, '0);
    rst_ni = 1'b1;
    a_in = 18'h3FFFF; b_in = 18'h2AAAA;
    step(); step();
    chk("R9 no edge from high clk at release AB", b_out, '0);
    chk("R9 no edge from high clk at release BA", a_out, '0);
    chk("R1 width", W'($bits(a_out)), W'(18));
  endtask

  task automatic t_oe();
    ab_oe = 1'b0; ba_oe_n = 1'b1; settle();
    chk("R6 b released", W'(b_oe), W'(0));
    chk("R7 a released", W'(a_oe), W'(0));
    ab_oe = 1'b1; settle();
    chk("R6 b driven", W'(b_oe), W'(1));
    chk("R7 a still released", W'(a_oe), W'(0));
    ba_oe_n = 1'b0; settle();
    chk("R7 a driven", W'(a_oe), W'(1));
    step();
  endtask

  task automatic t_transparent(input int d);
    set_le(d, 1'b1);
    set_src(d, 18'h15A3C); settle();
    chk("R2 pass p1", dst(d), 18'h15A3C);
    set_src(d, 18'h00001); settle();
    chk("R2 pass p2", dst(d), 18'h00001);
    step();
    set_src(d, 18'h3C3C3); settle();
    chk("R2 pass p3", dst(d), 18'h3C3C3);
    step();
  endtask

  task automatic t_hold(input int d);
    set_le(d, 1'b1); set_src(d, 18'h2A5C3); set_dclk(d, 1'b0);
    step();
    set_le(d, 1'b0); set_src(d, 18'h11111); settle();
    chk("R10 value from last le cycle", dst(d), 18'h2A5C3);
    step(); step();
    chk("R3 hold clk low", dst(d), 18'h2A5C3);
    set_le(d, 1'b1); set_dclk(d, 1'b1); set_src(d, 18'h0F0F0);
    step();
    set_le(d, 1'b0); set_src(d, 18'h22222);
    step(); step();
    chk("R3 hold clk high", dst(d), 18'h0F0F0);
  endtask

  task automatic t_capture(input int d);
    set_le(d, 1'b0); set_dclk(d, 1'b0); set_src(d, 18'h1B2C3);
    step();
    chk("R4 before edge", dst(d), 18'h0F0F0);
    set_dclk(d, 1'b1);
    step();
    chk("R4 load on rise", dst(d), 18'h1B2C3);
    set_src(d, 18'h3E3E3);
    step(); step();
    chk("R4 single load clk held high", dst(d), 18'h1B2C3);
  endtask

  task automatic t_le_fall_clk_low(input int d);
    set_dclk(d, 1'b0); set_le(d, 1'b1); set_src(d, 18'h01234);
    step();
    set_le(d, 1'b0); set_src(d, 18'h34567);
    step();
    chk("R5 held after le fall", dst(d), 18'h01234);
    set_dclk(d, 1'b1);
    step();
    chk("R5 new data on next rise", dst(d), 18'h34567);
  endtask

  task automatic t_clk_while_le(input int d);
    set_le(d, 1'b1);
    for (int i = 0; i < 3; i++) begin
      set_dclk(d, 1'b0); set_src(d, 18'h10000 + W'(i)); step();
      set_dclk(d, 1'b1); set_src(d, 18'h20000 + W'(i)); settle();
      chk("R10 pass during clocking", dst(d), 18'h20000 + W'(i));
      step();
    end
    set_le(d, 1'b0); set_src(d, 18'h0AAAA);
    step(); step();
    chk("R10 no extra load", dst(d), 18'h20002);
  endtask

  task automatic t_release_storage();
    ab_oe = 1'b0;
    ab_le = 1'b0; ab_clk = 1'b0; a_in = 18'h2DEAD;
    step();
    ab_clk = 1'b1;
    step();
    chk("R8 still released", W'(b_oe), W'(0));
    ab_oe = 1'b1; settle();
    chk("R8 load kept while released", b_out, 18'h2DEAD);
    chk("R8 driven again", W'(b_oe), W'(1));
    step();
  endtask

  task automatic t_indep();
    ba_le = 1'b0; ba_clk = 1'b1; b_in = 18'h0BEEF;
    step();
    ab_le = 1'b0; ab_clk = 1'b0; a_in = 18'h13579;
    step();
    ab_clk = 1'b1;
    step();
    chk("R1 A to B loaded", b_out, 18'h13579);
    chk("R1 B to A undisturbed", a_out, 18'h34567);
    ab_le = 1'b1; a_in = 18'h3FFFF; settle();
    chk("R1 B to A ignores A side transparency", a_out, 18'h34567);
    step();
  endtask

  initial begin
    t_reset();
    t_oe();
    for (int d = 0; d < 2; d++) begin
      t_transparent(d);
      t_hold(d);
      t_capture(d);
      t_le_fall_clk_low(d);
    end
    t_clk_while_le(0);
    t_release_storage();
    t_indep();
    t_clk_while_le(1);
    summary();
    $finish;
  end
endmodule